// File: doc/BRIEF.md
# Bit-masked control register bank with indirect configuration port

The block is a small control register bank on a simple single-cycle 32-bit bus. Every write carries its own per-bit write enable: the upper 16 bits of the written word choose which of the lower 16 bits actually change. This lets software touch one field without a read-modify-write. The bank has three registers. The first holds one idle bit per lane. The second is a port into a tiny internal configuration space. The third is a read-only status word.

The port register holds a config address, four bits of write data and a strobe bit. When the strobe bit goes from 0 to 1, the address and data held in the register are committed into the config space. Reads of the config space take a separate path, and an address can read back something different from what a write to it sets. Read data for the held address shows up in a nibble of the status register. A small stub PHY model supplies the read-side flags (PLL locked and reference-output gated) from input pins.

Register offsets on `bus_addr_i`: 0 is the lane-idle register, 1 is the config port register, 2 is status (read-only), and 3 is unmapped.

Top module: `masked_ctrl_bank`

## Requirements
- R1: A write of word W to register offset 0 or 1 sets stored bit n (n = 0..15) to W[n] only when W[n+16] is 1. A bit whose mask bit is clear keeps its value.
- R2: A read of offset 0 or 1 returns the stored 16 bits in bus_rdata_o[15:0]. bus_rdata_o[31:16] reads as zero for every offset.
- R3: After reset, offset 0 holds 0x0078 (lane-idle bits set), offset 1 holds 0, lane_idle_o is 4'hF, and sep_rate_o and ref_out_en_o are 0.
- R4: lane_idle_o[i] equals bit 3+i of the offset-0 register, for lanes i = 0..3.
- R5: In the offset-1 register, bit 0 is the strobe, bits [6:1] are the config address and bits [10:7] are the config data. A commit happens only on a 0-to-1 change of the stored strobe bit, and its effect is visible at the outputs one clock after the write that set the strobe. A write that leaves the strobe at 1 commits nothing.
- R6: A commit to config address 0x10 sets sep_rate_o to data bit 3. A commit to 0x12 sets ref_out_en_o to data bit 3. A commit to any other address changes neither output.
- R7: Status bits [11:8] hold the config read value for the held address. At 0x10 the value is pll_locked_i in bit 1, so status bit 9 follows that flag. At 0x12 the value is ref_gated_i in bit 2 (status bit 10). At any other address the value is zero. All other status bits are zero.
- R8: Writes to offset 2 or offset 3 change no register and no output, and offset 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register offset for read and write |
| bus_we_i | input | 1 | Single-cycle write enable |
| bus_wdata_i | input | 32 | Write word: mask in [31:16], data in [15:0] |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| pll_locked_i | input | 1 | Stub PHY: PLL locked flag |
| ref_gated_i | input | 1 | Stub PHY: reference output gated flag |
| lane_idle_o | output | 4 | Per-lane idle controls |
| sep_rate_o | output | 1 | Separate-rate mode selected through config space |
| ref_out_en_o | output | 1 | Reference output enabled through config space |

## Verification
The masked write is tried with four mask patterns: a full mask with zero data, a single-bit mask with all-ones data, a partial mask with mixed data, and an empty mask with all-ones data. Together these separate true per-bit gating from a whole-word write and from a write that ignores the mask. Strobe sequences include a first rise, a write that keeps the strobe high, and a re-arm followed by a new rise, so that an edge-triggered commit can be told apart from a level-triggered one. Both flag inputs are toggled while the held address is 0x10, 0x12 and an unused address, which shows that each flag reaches only its own status bit.

// File: rtl/masked_ctrl_pkg.sv
package masked_ctrl_pkg;
  localparam int HALF_W = 16;
  localparam int BUS_W  = 2 * HALF_W;

  typedef enum logic [1:0] {
    OFS_LANE = 2'd0,
    OFS_PORT = 2'd1,
    OFS_STAT = 2'd2,
    OFS_NONE = 2'd3
  } reg_ofs_e;

  // config space addresses
  localparam logic [5:0] CFG_PLL_ADR = 6'h10;
  localparam logic [5:0] CFG_REF_ADR = 6'h12;
  // bit positions inside the 4-bit config nibble
  localparam int CFG_MODE_BIT   = 3;
  localparam int CFG_LOCK_BIT   = 1;
  localparam int CFG_GATED_BIT  = 2;
  localparam int STAT_NIB_LSB   = 8;
endpackage

// File: rtl/wmask_reg.sv
module wmask_reg #(
  parameter int          W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [2*W-1:0] wdata_i,
  output logic [W-1:0]   q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    q_o[b] <= RST[b];
      else if (we_i && wdata_i[W+b])  q_o[b] <= wdata_i[b];
    end
  end
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit #(
  parameter int CFG_AW = 6,
  parameter int CFG_DW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] data_i,
  output logic              sep_rate_o,
  output logic              ref_out_en_o
);
  import masked_ctrl_pkg::*;

  logic strobe_q;
  logic commit;

  assign commit = strobe_i & ~strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sep_rate_o   <= 1'b0;
      ref_out_en_o <= 1'b0;
    end else if (commit) begin
      if (addr_i == CFG_AW'(CFG_PLL_ADR)) sep_rate_o   <= data_i[CFG_MODE_BIT];
      if (addr_i == CFG_AW'(CFG_REF_ADR)) ref_out_en_o <= data_i[CFG_MODE_BIT];
    end
  end
endmodule

// File: rtl/phy_stub.sv
module phy_stub #(
  parameter int CFG_AW = 6,
  parameter int CFG_DW = 4
) (
  input  logic [CFG_AW-1:0] addr_i,
  input  logic              pll_locked_i,
  input  logic              ref_gated_i,
  output logic [CFG_DW-1:0] rdata_o
);
  import masked_ctrl_pkg::*;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_AW'(CFG_PLL_ADR))      rdata_o[CFG_LOCK_BIT]  = pll_locked_i;
    else if (addr_i == CFG_AW'(CFG_REF_ADR)) rdata_o[CFG_GATED_BIT] = ref_gated_i;
  end
endmodule

// File: rtl/masked_ctrl_bank.sv
module masked_ctrl_bank #(
  parameter int LANES    = 4,
  parameter int LANE_LSB = 3,
  parameter int CFG_AW   = 6,
  parameter int CFG_DW   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_we_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic             pll_locked_i,
  input  logic             ref_gated_i,
  output logic [LANES-1:0] lane_idle_o,
  output logic             sep_rate_o,
  output logic             ref_out_en_o
);
  import masked_ctrl_pkg::*;

  localparam int HW = HALF_W;
  localparam logic [HW-1:0] LANE_RST = HW'(((1 << LANES) - 1) << LANE_LSB);
  localparam int ADR_LSB = 1;
  localparam int DAT_LSB = ADR_LSB + CFG_AW;

  logic              lane_we, port_we;
  logic [HW-1:0]     lane_q, port_q, stat_w;
  logic [CFG_AW-1:0] cfg_addr;
  logic [CFG_DW-1:0] cfg_data, cfg_rdata;

  assign lane_we = bus_we_i && (bus_addr_i == OFS_LANE);
  assign port_we = bus_we_i && (bus_addr_i == OFS_PORT);

  wmask_reg #(.W(HW), .RST(LANE_RST)) u_lane (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(lane_we),
    .wdata_i(bus_wdata_i), .q_o(lane_q)
  );

  wmask_reg #(.W(HW), .RST('0)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(port_we),
    .wdata_i(bus_wdata_i), .q_o(port_q)
  );

  assign lane_idle_o = lane_q[LANE_LSB +: LANES];
  assign cfg_addr    = port_q[ADR_LSB +: CFG_AW];
  assign cfg_data    = port_q[DAT_LSB +: CFG_DW];

  cfg_commit #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_commit (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(port_q[0]),
    .addr_i(cfg_addr), .data_i(cfg_data),
    .sep_rate_o(sep_rate_o), .ref_out_en_o(ref_out_en_o)
  );

  phy_stub #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_phy (
    .addr_i(cfg_addr), .pll_locked_i(pll_locked_i),
    .ref_gated_i(ref_gated_i), .rdata_o(cfg_rdata)
  );

  assign stat_w = HW'(cfg_rdata) << STAT_NIB_LSB;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_LANE: bus_rdata_o[HW-1:0] = lane_q;
      OFS_PORT: bus_rdata_o[HW-1:0] = port_q;
      OFS_STAT: bus_rdata_o[HW-1:0] = stat_w;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/masked_ctrl_bank_chk.sv
module masked_ctrl_bank_chk #(
  parameter int LANES    = 4,
  parameter int LANE_LSB = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       bus_addr_i,
  input logic             bus_we_i,
  input logic [31:0]      bus_wdata_i,
  input logic [31:0]      bus_rdata_o,
  input logic             pll_locked_i,
  input logic [LANES-1:0] lane_idle_o,
  input logic             sep_rate_o,
  input logic             ref_out_en_o,
  input logic [15:0]      port_q
);
  // R1
  masked_lane_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 2'd0) |=>
      lane_idle_o == (($past(bus_wdata_i[16+LANE_LSB +: LANES]) & $past(bus_wdata_i[LANE_LSB +: LANES]))
                    | (~$past(bus_wdata_i[16+LANE_LSB +: LANES]) & $past(lane_idle_o))));

  // R2
  upper_half_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[31:16] == 16'h0);

  // R5
  commit_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sep_rate_o) || !$stable(ref_out_en_o)) |->
      ($past(port_q[0]) && !$past(port_q[0], 2)));

  // R7
  lock_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 2'd2 && port_q[6:1] == 6'h10) |-> bus_rdata_o[9] == pll_locked_i);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 2'd3) |-> bus_rdata_o == 32'h0);
endmodule

bind masked_ctrl_bank masked_ctrl_bank_chk #(.LANES(LANES), .LANE_LSB(LANE_LSB)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pll_locked_i(pll_locked_i),
  .lane_idle_o(lane_idle_o), .sep_rate_o(sep_rate_o), .ref_out_en_o(ref_out_en_o),
  .port_q(port_q)
);

// File: tb/test_masked_ctrl_bank.sv
module test_masked_ctrl_bank;
  localparam int CLK_P = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [1:0]  a;
    logic [31:0] w;
    logic [15:0] r;
    logic [3:0]  idle;
  } vec_t;

  // offset, write word, expected read of same offset, expected lane_idle_o
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'hFFFF_0000, 16'h0000, 4'h0},
    '{2'd0, 32'h0008_FFFF, 16'h0008, 4'h1},
    '{2'd0, 32'h00F0_00A0, 16'h00A8, 4'h5},
    '{2'd0, 32'h0000_FFFF, 16'h00A8, 4'h5},
    '{2'd1, 32'hFFFF_1234, 16'h1234, 4'h5},
    '{2'd1, 32'h0F00_FFFF, 16'h1F34, 4'h5},
    '{2'd3, 32'hFFFF_FFFF, 16'h0000, 4'h5},
    '{2'd1, 32'h0000_0000, 16'h1F34, 4'h5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pll = 1'b0, gated = 1'b0;
  logic [3:0]  idle;
  logic        sep, refen;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  masked_ctrl_bank i_masked_ctrl_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pll_locked_i(pll),
    .ref_gated_i(gated), .lane_idle_o(idle), .sep_rate_o(sep), .ref_out_en_o(refen)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] w);
    @(negedge clk);
    addr = a; wdata = w; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    rd(2'd0, d); check("R3 lane reset", d, 32'h0000_0078);
    rd(2'd1, d); check("R3 port reset", d, 32'h0);
    check("R3 idle reset", {28'h0, idle}, 32'hF);
    check("R3 outputs reset", {30'h0, sep, refen}, 32'h0);

    // R1 R2 R4 R8 vector table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, d);
      check("R1/R2/R8 readback", d, {16'h0, VECS[i].r});
      check("R4 lane idle", {28'h0, idle}, {28'h0, VECS[i].idle});
    end

    // R5 R6: address 0x10, data bit3, strobe low -> no commit
    wr(2'd1, 32'hFFFF_0420);
    @(negedge clk);
    check("R5 no commit without strobe", {31'h0, sep}, 32'h0);
    wr(2'd1, 32'h0001_0001);
    @(negedge clk);
    check("R6 sep_rate set", {30'h0, sep, refen}, 32'h2);
    // strobe held high while data changes -> nothing committed
    wr(2'd1, 32'hFFFF_0021);
    @(negedge clk);
    check("R5 held strobe no commit", {31'h0, sep}, 32'h1);
    wr(2'd1, 32'h0001_0000);
    wr(2'd1, 32'h0001_0001);
    @(negedge clk);
    check("R5 re-armed commit clears sep", {31'h0, sep}, 32'h0);
    wr(2'd1, 32'hFFFF_0424);
    wr(2'd1, 32'h0001_0001);
    @(negedge clk);
    check("R6 ref_out_en set", {30'h0, sep, refen}, 32'h1);
    wr(2'd1, 32'hFFFF_078A);
    wr(2'd1, 32'h0001_0001);
    @(negedge clk);
    check("R6 other address no effect", {30'h0, sep, refen}, 32'h1);

    // R7 status read path
    wr(2'd1, 32'hFFFF_0020);
    pll = 1'b1; gated = 1'b0;
    rd(2'd2, d); check("R7 lock at 0x10", d, 32'h0000_0200);
    pll = 1'b0; gated = 1'b1;
    rd(2'd2, d); check("R7 gated hidden at 0x10", d, 32'h0);
    wr(2'd1, 32'hFFFF_0024);
    pll = 1'b1;
    rd(2'd2, d); check("R7 gated at 0x12", d, 32'h0000_0400);
    wr(2'd1, 32'hFFFF_000A);
    rd(2'd2, d); check("R7 other address zero", d, 32'h0);

    // R8 status write ignored
    wr(2'd1, 32'hFFFF_0024);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R8 status unchanged", d, 32'h0000_0400);
    rd(2'd1, d); check("R8 port unchanged", d, 32'h0000_0024);
    rd(2'd0, d); check("R8 lane unchanged", d, 32'h0000_00A8);
    check("R8 outputs unchanged", {30'h0, sep, refen}, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule